// File: doc/BRIEF.md
# Saturating Signed Add/Subtract Unit

This block does 32-bit signed arithmetic that clamps instead of wrapping. A 2-bit select picks one of four operations on two signed operands, `a` and `b`. It can add, subtract, add twice `b`, or subtract twice `b`. The doubling forms saturate twice. The doubled operand is clamped first, and the final sum or difference is clamped again.

An operation is accepted whenever the valid strobe is high. Its result is registered and appears on the next clock edge, together with a one-cycle result strobe. A sticky flag records that some clamp has happened since it was last cleared, and only the explicit clear input can lower it. Condition codes and register writeback belong to the surrounding logic.

Top module: `sat_arith_unit`

## Requirements
- R1: While reset is high, and in the cycle after reset is released, `res_q` is 0, `res_vld` is 0 and `sat_flag` is 0.
- R2: Select 2'b00 returns `a + b`. A positive overflow gives 32'h7FFFFFFF and a negative overflow gives 32'h80000000.
- R3: Select 2'b01 returns `a - b`, clamped to the same two limits as R2.
- R4: Select 2'b10 first doubles `b` and clamps the doubled value to the 32-bit signed range. It then adds that value to `a`, and clamps the sum again. Doubling 32'h40000000 gives 32'h7FFFFFFF, and doubling 32'hC0000000 gives 32'h80000000 with no clamp.
- R5: Select 2'b11 doubles and clamps `b` as in R4, then computes `a` minus that value and clamps the difference.
- R6: A strobe on `in_vld` at a clock edge produces `res_q` and a one-cycle `res_vld` pulse at that same edge. Both are visible for the following cycle. Without the strobe, `res_vld` is 0 and `res_q` keeps its last value.
- R7: An accepted operation in which either clamp step limits a value sets `sat_flag` at the result edge. An operation with no clamp leaves the flag unchanged.
- R8: `sat_clear` lowers `sat_flag` at the next edge. If an operation that clamps is accepted at the same edge, the flag is set instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Operation strobe |
| op_sel | input | 2 | 00 add, 01 sub, 10 doubled add, 11 doubled sub |
| opnd_a | input | 32 | Signed first operand |
| opnd_b | input | 32 | Signed second operand (the one doubled) |
| sat_clear | input | 1 | Clears the sticky flag |
| res_q | output | 32 | Registered saturated result |
| res_vld | output | 1 | Result strobe, one cycle after the operation |
| sat_flag | output | 1 | Sticky saturation flag |

## Verification
Every result, its strobe and any flag change are due exactly one edge after the cycle that carries the strobe or the clear. The bench drives its inputs on the falling edge. It drops the strobe on the next falling edge and samples outputs there, half a cycle after the capturing edge. Idle cycles are checked at the same point, to confirm that the result holds and the strobe stays low. The expected flag is carried in the bench from one operation to the next, so that sticky, set and clear-versus-set ordering are all judged at the sampled edge.

// File: rtl/sat_arith_pkg.sv
package sat_arith_pkg;

    localparam int unsigned DATA_W = 32;

    typedef enum logic [1:0] {
        OP_ADD  = 2'b00,
        OP_SUB  = 2'b01,
        OP_DADD = 2'b10,
        OP_DSUB = 2'b11
    } sat_op_e;

    typedef struct packed {
        logic [DATA_W-1:0] val;
        logic              clamped;
    } sat_word_t;

    function automatic logic [DATA_W-1:0] pos_limit();
        return {1'b0, {(DATA_W-1){1'b1}}};
    endfunction

    function automatic logic [DATA_W-1:0] neg_limit();
        return {1'b1, {(DATA_W-1){1'b0}}};
    endfunction

    // Wide (DATA_W+1 bit) value clamped back into DATA_W signed range.
    function automatic sat_word_t clamp_wide(input logic [DATA_W:0] w);
        sat_word_t r;
        if (w[DATA_W] != w[DATA_W-1]) begin
            r.clamped = 1'b1;
            r.val     = w[DATA_W] ? neg_limit() : pos_limit();
        end else begin
            r.clamped = 1'b0;
            r.val     = w[DATA_W-1:0];
        end
        return r;
    endfunction

endpackage

// File: rtl/sat_doubler.sv
module sat_doubler
    import sat_arith_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] x_i,
    output logic [W-1:0] y_o,
    output logic         clamp_o
);
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic [W:0] dbl_w;

    always_comb begin
        dbl_w = {x_i, 1'b0};
        // Doubling overflows when the two top bits of the input differ.
        if (x_i[W-1] != x_i[W-2]) begin
            clamp_o = 1'b1;
            y_o     = x_i[W-1] ? MINV : MAXV;
        end else begin
            clamp_o = 1'b0;
            y_o     = dbl_w[W-1:0];
        end
    end
endmodule

// File: rtl/sat_addsub.sv
module sat_addsub
    import sat_arith_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] y_o,
    output logic         clamp_o
);
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    logic [W:0] a_ext;
    logic [W:0] b_ext;
    logic [W:0] wide;

    always_comb begin
        a_ext = {a_i[W-1], a_i};
        b_ext = {b_i[W-1], b_i};
        wide  = sub_i ? (a_ext - b_ext) : (a_ext + b_ext);
        if (wide[W] != wide[W-1]) begin
            clamp_o = 1'b1;
            y_o     = wide[W] ? MINV : MAXV;
        end else begin
            clamp_o = 1'b0;
            y_o     = wide[W-1:0];
        end
    end
endmodule

// File: rtl/sat_sticky_flag.sv
module sat_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    always_ff @(posedge clk) begin
        if (rst)        flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end

    // R7: a clamp always leaves the flag raised
    a_r7_set_on_clamp: assert property (@(posedge clk) disable iff (rst)
        set_i |=> flag_o);

    // R7: without a clear, the flag never falls
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (flag_o && !clr_i) |=> flag_o);

    // R8: clear with no concurrent clamp lowers the flag
    a_r8_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !flag_o);
endmodule

// File: rtl/sat_arith_unit.sv
module sat_arith_unit
    import sat_arith_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_vld,
    input  logic [1:0]   op_sel,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         sat_clear,
    output logic [W-1:0] res_q,
    output logic         res_vld,
    output logic         sat_flag
);
    localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
    localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

    sat_op_e     op;
    logic [W-1:0] b_dbl;
    logic         dbl_clamp;
    logic [W-1:0] b_sel;
    logic [W-1:0] sum_val;
    logic         sum_clamp;
    logic         clamp_any;
    logic         use_dbl;
    logic         is_sub;

    assign op      = sat_op_e'(op_sel);
    assign use_dbl = (op == OP_DADD) || (op == OP_DSUB);
    assign is_sub  = (op == OP_SUB)  || (op == OP_DSUB);

    sat_doubler #(.W(W)) u_dbl (
        .x_i     (opnd_b),
        .y_o     (b_dbl),
        .clamp_o (dbl_clamp)
    );

    assign b_sel = use_dbl ? b_dbl : opnd_b;

    sat_addsub #(.W(W)) u_as (
        .a_i     (opnd_a),
        .b_i     (b_sel),
        .sub_i   (is_sub),
        .y_o     (sum_val),
        .clamp_o (sum_clamp)
    );

    assign clamp_any = sum_clamp || (use_dbl && dbl_clamp);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            res_vld <= 1'b0;
        end else begin
            res_vld <= in_vld;
            if (in_vld) res_q <= sum_val;
        end
    end

    sat_sticky_flag u_flag (
        .clk    (clk),
        .rst    (rst),
        .set_i  (in_vld && clamp_any),
        .clr_i  (sat_clear),
        .flag_o (sat_flag)
    );

    // R6: result strobe follows the input strobe by one edge
    a_r6_valid_latency: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> res_vld);

    // R6: idle cycles keep the result
    a_r6_hold_result: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> ($stable(res_q) && !res_vld));

    // R2: a clamped result is one of the two signed limits
    a_r2_clamp_limits: assert property (@(posedge clk) disable iff (rst)
        (in_vld && sum_clamp) |=> (res_q == MAXV || res_q == MINV));

    // R4: an overflowing double yields a signed limit before the add
    a_r4_dbl_limits: assert property (@(posedge clk) disable iff (rst)
        (use_dbl && dbl_clamp) |-> (b_dbl == MAXV || b_dbl == MINV));
endmodule

// File: tb/sat_arith_unit_tb.sv
module sat_arith_unit_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_vld;
    logic [1:0]  op_sel;
    logic [31:0] opnd_a;
    logic [31:0] opnd_b;
    logic        sat_clear;
    logic [31:0] res_q;
    logic        res_vld;
    logic        sat_flag;

    int checks = 0;
    int bad    = 0;
    logic exp_flag = 1'b0;
    logic [31:0] last_res = 32'h0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sat_arith_unit dut_i (
        .clk(clk), .rst(rst), .in_vld(in_vld), .op_sel(op_sel),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .sat_clear(sat_clear),
        .res_q(res_q), .res_vld(res_vld), .sat_flag(sat_flag)
    );

    function automatic longint clampv(input longint v, inout bit hit);
        if (v > 64'sd2147483647)  begin hit = 1; return 64'sd2147483647; end
        if (v < -64'sd2147483648) begin hit = 1; return -64'sd2147483648; end
        return v;
    endfunction

    function automatic logic [31:0] model(input logic [1:0] op, input logic [31:0] a,
                                          input logic [31:0] b, output bit hit);
        longint av = longint'($signed(a));
        longint bv = longint'($signed(b));
        longint r;
        hit = 0;
        if (op[1]) bv = clampv(bv * 2, hit);
        r = op[0] ? av - bv : av + bv;
        r = clampv(r, hit);
        return r[31:0];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic run_op(input string req, input logic [1:0] op, input logic [31:0] a,
                          input logic [31:0] b, input logic clr);
        bit hit;
        logic [31:0] e;
        @(negedge clk);
        in_vld = 1; op_sel = op; opnd_a = a; opnd_b = b; sat_clear = clr;
        e = model(op, a, b, hit);
        exp_flag = (clr ? 1'b0 : exp_flag) | hit;
        @(negedge clk);
        in_vld = 0; sat_clear = 0;
        check(req, res_q, e);
        check("R6", {31'b0, res_vld}, 32'd1);
        check(hit ? "R7" : "R8", {31'b0, sat_flag}, {31'b0, exp_flag});
        last_res = e;
    endtask

    task automatic idle_check(input logic clr);
        @(negedge clk);
        in_vld = 0; sat_clear = clr; opnd_a = $urandom; opnd_b = $urandom; op_sel = 2'b10;
        if (clr) exp_flag = 0;
        @(negedge clk);
        sat_clear = 0;
        check("R6", res_q, last_res);
        check("R6", {31'b0, res_vld}, 32'd0);
        check("R8", {31'b0, sat_flag}, {31'b0, exp_flag});
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1; in_vld = 0; op_sel = 0; opnd_a = 0; opnd_b = 0; sat_clear = 0;
        repeat (3) @(negedge clk);
        check("R1", res_q, 32'h0);
        check("R1", {31'b0, res_vld}, 32'd0);
        check("R1", {31'b0, sat_flag}, 32'd0);
        rst = 0;
        @(negedge clk);
        check("R1", {31'b0, sat_flag}, 32'd0);

        run_op("R2", 2'b00, 32'd5, 32'd7, 0);
        idle_check(0);
        run_op("R2", 2'b00, 32'h7FFFFFF0, 32'h00000100, 0);
        run_op("R2", 2'b00, 32'h80000010, 32'hFFFFFF00, 0);
        idle_check(1);
        run_op("R3", 2'b01, 32'h00000010, 32'h00000020, 0);
        run_op("R3", 2'b01, 32'h80000000, 32'h00000001, 0);
        run_op("R3", 2'b01, 32'h7FFFFFFF, 32'hFFFFFFFF, 1);
        idle_check(1);
        run_op("R4", 2'b10, 32'h00000000, 32'h40000000, 0);
        idle_check(1);
        run_op("R4", 2'b10, 32'h00000000, 32'hC0000000, 0);
        run_op("R4", 2'b10, 32'h00000003, 32'h00000004, 0);
        run_op("R4", 2'b10, 32'h40000000, 32'h30000000, 1);
        idle_check(1);
        run_op("R5", 2'b11, 32'h00000000, 32'hC0000000, 0);
        idle_check(1);
        run_op("R5", 2'b11, 32'h80000000, 32'h80000000, 0);
        run_op("R5", 2'b11, 32'h00000100, 32'h00000010, 0);
        idle_check(1);
        run_op("R8", 2'b00, 32'h7FFFFFFF, 32'h00000001, 1);
        idle_check(0);
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra = $urandom;
            logic [31:0] rb = $urandom;
            if (i % 4 == 1) ra = {{4{ra[31]}}, ra[27:0]};
            if (i % 4 == 2) rb = {{8{rb[31]}}, rb[23:0]};
            run_op("R2-5 random", 2'(i), ra, rb, ($urandom % 5) == 0);
            if (i % 17 == 0) idle_check(($urandom % 2) == 0);
        end
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule